// File: doc/BRIEF.md
# Region Split/Merge Mapping-Entry Rewriter

This block sits beside a region mapping table used for wear-leveling. Each table slot covers a base region of P = 2^KMIN lines and holds an entry of fixed width ENTRY_W. An entry packs a physical region field in its upper bits and an XOR offset key in its lower `klen` bits. When several base regions are joined into one larger region, every slot of that run carries the same entry and the same `klen`. Joining two runs moves one bit from the region field into the key. Cutting a run in half moves one bit back. Because lines are placed by XORing their offset with the key, a split needs no data movement. The table only has to be rewritten.

On a request the block takes the run's first table index, its current entry and its `klen`. It then emits the rewritten slots on a write port, one slot per cycle, and raises `done` when the run is finished. A request it cannot carry out raises `reject` and writes nothing. A second, independent path accepts a stream of table slots in index order. For each run of adjacent identical slots it reports the run's true granularity in lines.

FSM states: ST_IDLE (waiting), ST_SPLIT_LO (writing the lower half of a split), ST_SPLIT_HI (writing the upper half), ST_MERGE (writing a merged run), ST_FINISH (one-cycle done), ST_REFUSE (one-cycle reject). The transitions are:
- IDLE→SPLIT_LO on an accepted split.
- IDLE→MERGE on an accepted merge.
- IDLE→REFUSE on an illegal request.
- SPLIT_LO→SPLIT_HI after the last lower-half slot.
- SPLIT_HI→FINISH after the last upper-half slot.
- MERGE→FINISH after the last slot.
- FINISH→IDLE and REFUSE→IDLE unconditionally.

The scan path has the states RUN_EMPTY and RUN_OPEN. It moves EMPTY→OPEN on the first valid slot and OPEN→EMPTY on `scan_end`.

Top module: `region_entry_rewriter`

## Requirements
- R1: After reset, `busy`, `wr_valid`, `done`, `reject` and `gran_valid` are all 0.
- R2: A request (`req_valid`=1) is taken only while `busy`=0, and `busy` is 1 in the cycle after it is taken. A request presented while `busy`=1 has no effect on the slots written.
- R3: An accepted split or merge writes consecutive table indices, one per cycle, starting at `req_index` in the cycle after acceptance. All slots of one request carry the same `wr_klen`. A split writes 2^(k−KMIN) slots with `wr_klen`=k−1, where k=`req_klen`.
- R4: Entry layout: region field = entry[ENTRY_W−1:k], key = entry[k−1:0]. In a split, the slots of the lower half of indices get region = {old region, key[k−1]}. The slots of the upper half get region = {old region, ~key[k−1]}. In both halves the key is old key[k−2:0]. The two halves therefore differ in exactly one bit.
- R5: A split is rejected when k < KMIN+1 or k > KMAX.
- R6: A merge writes 2^(k−KMIN+1) slots with `wr_klen`=k+1. The new region is the old region without its LSB, and the new key is {old region LSB, old key}.
- R7: A merge is rejected when k < KMIN or k+1 > KMAX.
- R8: A request is rejected when `req_index` is not a multiple of the number of slots it would write. A rejected request pulses `reject` for one cycle, in the cycle after acceptance, and writes nothing.
- R9: `done` is 1 for exactly one cycle, the cycle after the last write. `busy` returns to 0 in the cycle after `done` or `reject`. `wr_valid`, `done` and `reject` are never high together.
- R10: On the scan path, two slots are identical when both entry and `klen` match. When a valid slot differs from the open run, `gran_valid` is 1 in the next cycle with `gran_lines` = P × (run length). `scan_end` with `scan_valid`=0 closes an open run in the same way. `scan_end` with no open run reports nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_merge | input | 1 | 1 = merge, 0 = split |
| req_index | input | IDX_W | First table index of the run |
| req_entry | input | ENTRY_W | Current entry of the run |
| req_klen | input | KL_W | Current key width k |
| busy | output | 1 | Request in progress |
| wr_valid | output | 1 | Slot write strobe |
| wr_index | output | IDX_W | Table index being written |
| wr_entry | output | ENTRY_W | New entry |
| wr_klen | output | KL_W | New key width |
| done | output | 1 | Run fully rewritten |
| reject | output | 1 | Request refused |
| scan_valid | input | 1 | Scanned slot strobe |
| scan_entry | input | ENTRY_W | Scanned entry |
| scan_klen | input | KL_W | Scanned key width |
| scan_end | input | 1 | Close the open run |
| gran_valid | output | 1 | Granularity result strobe |
| gran_lines | output | GRAN_W | Granularity of the closed run in lines |

## Verification
Every cycle, the assertions check the following:
- the write, done and reject pulses are mutually exclusive;
- `busy` rises after acceptance and falls after `done` or `reject`;
- successive writes step the index by one and hold `wr_klen`;
- neighbouring written entries differ in at most one bit;
- a falling write strobe is followed at once by `done`.

The actual bit values of the split halves and of merged entries can only be shown by the bench's scenarios. The same holds for the accept and reject decisions at each range and alignment edge, the ignoring of a request while busy, and the run lengths reported by the scan path.

// File: rtl/rer_pkg.sv
package rer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_SPLIT_LO = 3'd1,
        ST_SPLIT_HI = 3'd2,
        ST_MERGE    = 3'd3,
        ST_FINISH   = 3'd4,
        ST_REFUSE   = 3'd5
    } rer_state_e;

    typedef enum logic {
        RUN_EMPTY = 1'b0,
        RUN_OPEN  = 1'b1
    } run_state_e;

endpackage

// File: rtl/rer_req_check.sv
// Decides whether a split or merge request is legal and how many
// slots each write phase covers.
module rer_req_check #(
    parameter int IDX_W = 6,
    parameter int KL_W  = 4,
    parameter int KMIN  = 2,
    parameter int KMAX  = 8
) (
    input  logic              is_merge,
    input  logic [IDX_W-1:0]  base_idx,
    input  logic [KL_W-1:0]   klen,
    output logic              accept_ok,
    output logic [IDX_W-1:0]  phase_last
);

    int   k_val;
    int   level;
    int   span;
    logic range_ok;
    logic aligned;

    always_comb begin
        k_val = int'(klen);
        if (is_merge) begin
            // key grows by one bit: k must lie in [KMIN, KMAX-1]
            range_ok = (k_val >= KMIN) && (k_val + 1 <= KMAX);
            level    = k_val - KMIN + 1;
        end else begin
            // key shrinks by one bit: never below the base width
            range_ok = (k_val >= KMIN + 1) && (k_val <= KMAX);
            level    = k_val - KMIN;
        end
        if (!range_ok) begin
            level = 0;
        end
        span      = 1 << level;
        aligned   = ((int'(base_idx) & (span - 1)) == 0);
        accept_ok = range_ok && aligned;
        if (is_merge) begin
            phase_last = IDX_W'(span - 1);
        end else begin
            phase_last = IDX_W'((span >> 1) - 1);
        end
    end

endmodule

// File: rtl/rer_entry_xform.sv
// Field algebra: unpacks {region, key} at the klen boundary and
// repacks with the boundary moved by one bit.
module rer_entry_xform #(
    parameter int ENTRY_W = 12,
    parameter int KL_W    = 4
) (
    input  logic [ENTRY_W-1:0] old_entry,
    input  logic [KL_W-1:0]    old_klen,
    input  logic               is_merge,
    input  logic               upper_half,
    output logic [ENTRY_W-1:0] new_entry,
    output logic [KL_W-1:0]    new_klen
);

    logic [ENTRY_W-1:0] key_mask;
    logic [ENTRY_W-1:0] region_f;
    logic [ENTRY_W-1:0] key_f;
    logic [ENTRY_W-1:0] key_shifted;
    logic [ENTRY_W-1:0] key_next;
    logic [ENTRY_W-1:0] region_next;
    logic               key_top;

    always_comb begin
        key_mask    = ~({ENTRY_W{1'b1}} << old_klen);
        region_f    = old_entry >> old_klen;
        key_f       = old_entry & key_mask;
        key_shifted = key_f >> (old_klen - 1'b1);
        key_top     = key_shifted[0];
        key_next    = '0;
        region_next = '0;
        new_entry   = '0;
        new_klen    = '0;
        if (is_merge) begin
            // region LSB becomes the new key MSB
            region_next = region_f >> 1;
            key_next    = key_f | ({{(ENTRY_W-1){1'b0}}, region_f[0]} << old_klen);
            new_klen    = old_klen + 1'b1;
            new_entry   = (region_next << new_klen) | key_next;
        end else begin
            // key MSB, XORed with the half index, becomes the region LSB
            region_next = (region_f << 1) |
                          {{(ENTRY_W-1){1'b0}}, key_top ^ upper_half};
            key_next    = key_f & (key_mask >> 1);
            new_klen    = old_klen - 1'b1;
            new_entry   = (region_next << new_klen) | key_next;
        end
    end

endmodule

// File: rtl/rer_run_meter.sv
// Measures runs of adjacent identical slots; reports P * run length.
module rer_run_meter
    import rer_pkg::*;
#(
    parameter int ENTRY_W = 12,
    parameter int KL_W    = 4,
    parameter int IDX_W   = 6,
    parameter int KMIN    = 2,
    localparam int CNT_W  = IDX_W + 1,
    localparam int GRAN_W = CNT_W + KMIN
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scan_valid,
    input  logic [ENTRY_W-1:0] scan_entry,
    input  logic [KL_W-1:0]    scan_klen,
    input  logic               scan_end,
    output logic               gran_valid,
    output logic [GRAN_W-1:0]  gran_lines
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(1 << IDX_W);

    run_state_e         run_st;
    logic [ENTRY_W-1:0] cur_entry;
    logic [KL_W-1:0]    cur_klen;
    logic [CNT_W-1:0]   run_cnt;
    logic               same_slot;

    assign same_slot = (scan_entry == cur_entry) && (scan_klen == cur_klen);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_st     <= RUN_EMPTY;
            cur_entry  <= '0;
            cur_klen   <= '0;
            run_cnt    <= '0;
            gran_valid <= 1'b0;
            gran_lines <= '0;
        end else begin
            gran_valid <= 1'b0;
            unique case (run_st)
                RUN_EMPTY: begin
                    if (scan_valid) begin
                        run_st    <= RUN_OPEN;
                        cur_entry <= scan_entry;
                        cur_klen  <= scan_klen;
                        run_cnt   <= CNT_W'(1);
                    end
                end
                RUN_OPEN: begin
                    if (scan_valid) begin
                        if (same_slot) begin
                            if (run_cnt != CNT_MAX) begin
                                run_cnt <= run_cnt + 1'b1;
                            end
                        end else begin
                            gran_valid <= 1'b1;
                            gran_lines <= {run_cnt, {KMIN{1'b0}}};
                            cur_entry  <= scan_entry;
                            cur_klen   <= scan_klen;
                            run_cnt    <= CNT_W'(1);
                        end
                    end else if (scan_end) begin
                        gran_valid <= 1'b1;
                        gran_lines <= {run_cnt, {KMIN{1'b0}}};
                        run_st     <= RUN_EMPTY;
                    end
                end
                default: run_st <= RUN_EMPTY;
            endcase
        end
    end

endmodule

// File: rtl/region_entry_rewriter.sv
module region_entry_rewriter
    import rer_pkg::*;
#(
    parameter int ENTRY_W = 12,
    parameter int IDX_W   = 6,
    parameter int KMIN    = 2,
    parameter int KMAX    = KMIN + IDX_W,
    localparam int KL_W   = $clog2(ENTRY_W + 1),
    localparam int GRAN_W = IDX_W + 1 + KMIN
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_merge,
    input  logic [IDX_W-1:0]   req_index,
    input  logic [ENTRY_W-1:0] req_entry,
    input  logic [KL_W-1:0]    req_klen,
    output logic               busy,
    output logic               wr_valid,
    output logic [IDX_W-1:0]   wr_index,
    output logic [ENTRY_W-1:0] wr_entry,
    output logic [KL_W-1:0]    wr_klen,
    output logic               done,
    output logic               reject,
    input  logic               scan_valid,
    input  logic [ENTRY_W-1:0] scan_entry,
    input  logic [KL_W-1:0]    scan_klen,
    input  logic               scan_end,
    output logic               gran_valid,
    output logic [GRAN_W-1:0]  gran_lines
);

    rer_state_e         state;
    rer_state_e         state_nx;
    logic [IDX_W-1:0]   r_base;
    logic [IDX_W-1:0]   r_off;
    logic [IDX_W-1:0]   r_last;
    logic [ENTRY_W-1:0] r_entry;
    logic [KL_W-1:0]    r_klen;
    logic               r_merge;

    logic               req_ok;
    logic [IDX_W-1:0]   req_last;
    logic [IDX_W-1:0]   hi_last;
    logic               in_upper;
    logic [ENTRY_W-1:0] xf_entry;
    logic [KL_W-1:0]    xf_klen;

    rer_req_check #(
        .IDX_W (IDX_W),
        .KL_W  (KL_W),
        .KMIN  (KMIN),
        .KMAX  (KMAX)
    ) u_check (
        .is_merge   (req_merge),
        .base_idx   (req_index),
        .klen       (req_klen),
        .accept_ok  (req_ok),
        .phase_last (req_last)
    );

    assign in_upper = (state == ST_SPLIT_HI);
    assign hi_last  = {r_last[IDX_W-2:0], 1'b1};

    rer_entry_xform #(
        .ENTRY_W (ENTRY_W),
        .KL_W    (KL_W)
    ) u_xform (
        .old_entry  (r_entry),
        .old_klen   (r_klen),
        .is_merge   (r_merge),
        .upper_half (in_upper),
        .new_entry  (xf_entry),
        .new_klen   (xf_klen)
    );

    rer_run_meter #(
        .ENTRY_W (ENTRY_W),
        .KL_W    (KL_W),
        .IDX_W   (IDX_W),
        .KMIN    (KMIN)
    ) u_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .scan_valid (scan_valid),
        .scan_entry (scan_entry),
        .scan_klen  (scan_klen),
        .scan_end   (scan_end),
        .gran_valid (gran_valid),
        .gran_lines (gran_lines)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!req_ok) begin
                        state_nx = ST_REFUSE;
                    end else if (req_merge) begin
                        state_nx = ST_MERGE;
                    end else begin
                        state_nx = ST_SPLIT_LO;
                    end
                end
            end
            ST_SPLIT_LO: if (r_off == r_last)  state_nx = ST_SPLIT_HI;
            ST_SPLIT_HI: if (r_off == hi_last) state_nx = ST_FINISH;
            ST_MERGE:    if (r_off == r_last)  state_nx = ST_FINISH;
            ST_FINISH:   state_nx = ST_IDLE;
            ST_REFUSE:   state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // request capture and slot counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_base  <= '0;
            r_off   <= '0;
            r_last  <= '0;
            r_entry <= '0;
            r_klen  <= '0;
            r_merge <= 1'b0;
        end else if (state == ST_IDLE) begin
            if (req_valid) begin
                r_base  <= req_index;
                r_off   <= '0;
                r_last  <= req_last;
                r_entry <= req_entry;
                r_klen  <= req_klen;
                r_merge <= req_merge;
            end
        end else if (state == ST_SPLIT_LO || state == ST_SPLIT_HI ||
                     state == ST_MERGE) begin
            r_off <= r_off + 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy     = 1'b1;
        wr_valid = 1'b0;
        done     = 1'b0;
        reject   = 1'b0;
        wr_index = r_base + r_off;
        wr_entry = xf_entry;
        wr_klen  = xf_klen;
        unique case (state)
            ST_IDLE:     busy = 1'b0;
            ST_SPLIT_LO: wr_valid = 1'b1;
            ST_SPLIT_HI: wr_valid = 1'b1;
            ST_MERGE:    wr_valid = 1'b1;
            ST_FINISH:   done = 1'b1;
            ST_REFUSE:   reject = 1'b1;
            default:     busy = 1'b1;
        endcase
    end

endmodule

// File: rtl/rer_checker.sv
module rer_checker #(
    parameter int ENTRY_W = 12,
    parameter int IDX_W   = 6,
    parameter int KL_W    = 4,
    parameter int GRAN_W  = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               busy,
    input logic               wr_valid,
    input logic [IDX_W-1:0]   wr_index,
    input logic [ENTRY_W-1:0] wr_entry,
    input logic [KL_W-1:0]    wr_klen,
    input logic               done,
    input logic               reject,
    input logic               gran_valid,
    input logic [GRAN_W-1:0]  gran_lines
);

    p_pulse_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_valid, done, reject}));

    p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done || reject) |=> !busy);

    p_index_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && $past(wr_valid)) |-> (wr_index == IDX_W'($past(wr_index) + 1'b1)));

    p_klen_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && $past(wr_valid)) |-> (wr_klen == $past(wr_klen)));

    p_one_bit_apart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && $past(wr_valid) && (wr_entry != $past(wr_entry)))
            |-> ($countones(wr_entry ^ $past(wr_entry)) == 1));

    p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_valid) |-> done);

    p_gran_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        gran_valid |-> (gran_lines != '0));

endmodule

bind region_entry_rewriter rer_checker #(
    .ENTRY_W (ENTRY_W),
    .IDX_W   (IDX_W),
    .KL_W    (KL_W),
    .GRAN_W  (GRAN_W)
) u_rer_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .busy       (busy),
    .wr_valid   (wr_valid),
    .wr_index   (wr_index),
    .wr_entry   (wr_entry),
    .wr_klen    (wr_klen),
    .done       (done),
    .reject     (reject),
    .gran_valid (gran_valid),
    .gran_lines (gran_lines)
);

// File: tb/region_entry_rewriter_test.sv
`timescale 1ns/1ps
module region_entry_rewriter_test;

    localparam int ENTRY_W = 12;
    localparam int IDX_W   = 6;
    localparam int KMIN    = 2;
    localparam int KL_W    = 4;
    localparam int GRAN_W  = IDX_W + 1 + KMIN;
    localparam int NVEC    = 11;

    // {merge, index[5:0], entry[11:0], klen[3:0], expect_reject}
    localparam logic [23:0] VEC [NVEC] = '{
        {1'b0, 6'd8,  12'hA5C, 4'd4, 1'b0},
        {1'b0, 6'd2,  12'h3F6, 4'd3, 1'b0},
        {1'b0, 6'd0,  12'h111, 4'd2, 1'b1},
        {1'b0, 6'd4,  12'h0F0, 4'd5, 1'b1},
        {1'b1, 6'd6,  12'h123, 4'd2, 1'b0},
        {1'b1, 6'd16, 12'hB7E, 4'd4, 1'b0},
        {1'b1, 6'd0,  12'h222, 4'd8, 1'b1},
        {1'b1, 6'd2,  12'h456, 4'd3, 1'b1},
        {1'b0, 6'd0,  12'hFFF, 4'd8, 1'b0},
        {1'b1, 6'd0,  12'h0AB, 4'd1, 1'b1},
        {1'b0, 6'd0,  12'h0CD, 4'd9, 1'b1}
    };

    logic               clk = 1'b0;
    logic               rst_n;
    logic               req_valid;
    logic               req_merge;
    logic [IDX_W-1:0]   req_index;
    logic [ENTRY_W-1:0] req_entry;
    logic [KL_W-1:0]    req_klen;
    logic               busy, wr_valid, done, reject;
    logic [IDX_W-1:0]   wr_index;
    logic [ENTRY_W-1:0] wr_entry;
    logic [KL_W-1:0]    wr_klen;
    logic               scan_valid, scan_end;
    logic [ENTRY_W-1:0] scan_entry;
    logic [KL_W-1:0]    scan_klen;
    logic               gran_valid;
    logic [GRAN_W-1:0]  gran_lines;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    region_entry_rewriter uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_merge(req_merge), .req_index(req_index),
        .req_entry(req_entry), .req_klen(req_klen),
        .busy(busy), .wr_valid(wr_valid), .wr_index(wr_index),
        .wr_entry(wr_entry), .wr_klen(wr_klen), .done(done), .reject(reject),
        .scan_valid(scan_valid), .scan_entry(scan_entry), .scan_klen(scan_klen),
        .scan_end(scan_end), .gran_valid(gran_valid), .gran_lines(gran_lines)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int exp_entry(input bit m, input int ent, input int k, input bit hi);
        int region, key, top, nreg, nkey;
        region = ent >> k;
        key    = ent & ((1 << k) - 1);
        if (m) begin
            nreg = region >> 1;
            nkey = ((region & 1) << k) | key;
            return ((nreg << (k + 1)) | nkey) & 12'hFFF;
        end
        top  = (key >> (k - 1)) & 1;
        nreg = (region << 1) | (top ^ int'(hi));
        nkey = key & ((1 << (k - 1)) - 1);
        return ((nreg << (k - 1)) | nkey) & 12'hFFF;
    endfunction

    task automatic run_op(input bit m, input int idx, input int ent, input int k,
                          input bit exp_rej, input bit poke);
        int n;
        int e_exp;
        int k_exp;
        @(negedge clk);
        req_valid = 1'b1;
        req_merge = m;
        req_index = IDX_W'(idx);
        req_entry = ENTRY_W'(ent);
        req_klen  = KL_W'(k);
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R2", "busy after accept", longint'(busy), 1);
        if (exp_rej) begin
            // R5 R7 R8: refused request pulses reject, writes nothing
            check(reject == 1'b1 && wr_valid == 1'b0, "R5 R7 R8", "reject pulse",
                  longint'({reject, wr_valid}), 2);
            @(negedge clk);
            check(busy == 1'b0 && reject == 1'b0, "R9", "release after reject",
                  longint'({busy, reject}), 0);
            return;
        end
        n     = m ? (1 << (k - KMIN + 1)) : (1 << (k - KMIN));
        k_exp = m ? k + 1 : k - 1;
        for (int i = 0; i < n; i++) begin
            if (poke && i == 1) begin
                req_valid = 1'b1;
                req_merge = ~m;
                req_index = IDX_W'(idx + 1);
                req_entry = ~ENTRY_W'(ent);
            end
            if (poke && i == 2) begin
                req_valid = 1'b0;
            end
            e_exp = exp_entry(m, ent, k, i >= n / 2);
            check(wr_valid == 1'b1 && wr_index == IDX_W'(idx + i) &&
                  wr_entry == ENTRY_W'(e_exp) && wr_klen == KL_W'(k_exp),
                  m ? "R3 R6" : (poke ? "R2 R3 R4" : "R3 R4"), "slot {v,idx,entry,klen}",
                  longint'({wr_valid, wr_index, wr_entry, wr_klen}),
                  longint'({1'b1, IDX_W'(idx + i), ENTRY_W'(e_exp), KL_W'(k_exp)}));
            @(negedge clk);
        end
        req_valid = 1'b0;
        check(done == 1'b1 && wr_valid == 1'b0, "R9", "done after last write",
              longint'({done, wr_valid}), 2);
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R9", "single done, busy released",
              longint'({busy, done}), 0);
    endtask

    task automatic scan_step(input bit v, input int ent, input int k, input bit e_end,
                             input bit exp_v, input int exp_lines);
        scan_valid = v;
        scan_entry = ENTRY_W'(ent);
        scan_klen  = KL_W'(k);
        scan_end   = e_end;
        @(negedge clk);
        scan_valid = 1'b0;
        scan_end   = 1'b0;
        if (exp_v) begin
            check(gran_valid == 1'b1 && gran_lines == GRAN_W'(exp_lines), "R10",
                  "granularity", longint'({gran_valid, gran_lines}),
                  longint'({1'b1, GRAN_W'(exp_lines)}));
        end else begin
            check(gran_valid == 1'b0, "R10", "no granularity", longint'(gran_valid), 0);
        end
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_merge = 1'b0; req_index = '0;
        req_entry = '0; req_klen = '0; scan_valid = 1'b0; scan_entry = '0;
        scan_klen = '0; scan_end = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check({busy, wr_valid, done, reject, gran_valid} == 5'b0, "R1", "reset outputs",
              longint'({busy, wr_valid, done, reject, gran_valid}), 0);

        for (int v = 0; v < NVEC; v++) begin
            run_op(VEC[v][23], int'(VEC[v][22:17]), int'(VEC[v][16:5]),
                   int'(VEC[v][4:1]), VEC[v][0], 1'b0);
        end

        // R2: request during a busy split is ignored
        run_op(1'b0, 0, 12'h5A3, 4, 1'b0, 1'b1);

        // R10: runs of 3 and 2 slots, a klen-only difference, and an idle end
        @(negedge clk);
        scan_step(1'b1, 12'h0C8, 3, 1'b0, 1'b0, 0);
        scan_step(1'b1, 12'h0C8, 3, 1'b0, 1'b0, 0);
        scan_step(1'b1, 12'h0C8, 3, 1'b0, 1'b0, 0);
        scan_step(1'b1, 12'h0C8, 2, 1'b0, 1'b1, 3 * 4);
        scan_step(1'b1, 12'h0C8, 2, 1'b0, 1'b0, 0);
        scan_step(1'b0, 0, 0, 1'b1, 1'b1, 2 * 4);
        scan_step(1'b0, 0, 0, 1'b1, 1'b0, 0);
        scan_step(1'b1, 12'h777, 4, 1'b0, 1'b0, 0);
        scan_step(1'b0, 0, 0, 1'b1, 1'b1, 1 * 4);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule